// File: doc/BRIEF.md
# Card Clock Source Selector

This block produces the clock that drives a smart card contact. It works in the crystal clock domain and can deliver the crystal clock divided by two, four or eight, a slower clock taken from an internal oscillator, or a clock held still at a chosen high or low level. The host writes a configuration word with a single-cycle write strobe. The block keeps that word as the requested setting and moves its active setting over to it only when doing so cannot create a short pulse on the card clock.

The card clock is a register output, so it never carries combinational glitches. The internal oscillator is treated as an asynchronous input and enters through a two-flop synchronizer. Between two running settings, a switch is held back until the level that the new source presents matches the level the card clock already has. A completion flag is low while a requested change is still waiting, and it goes high once the active setting matches the request.

A write that starts or stops the clock may change only the stop bits. If such a write carries a different divider code, that code is discarded and the divider already requested is kept, so the clock always resumes at the rate it had before it stopped.

Top module: `card_clk_sel`

## Requirements
- R1: While `rst` is high and after it is released, `card_clk` is 0, `sw_done` is 1 and the active setting is stopped-low with divider code 00.
- R2: With `cfg_stop`=0 and `cfg_int_sel`=0, divider code 00 gives a `card_clk` period of 2 crystal cycles, code 01 gives 4 and code 10 gives 8.
- R3: With `cfg_stop`=1 active, `card_clk` stays at the level of `cfg_stop_high` (1 = high, 0 = low) on every cycle.
- R4: With `cfg_stop`=0 and `cfg_int_sel`=1, `card_clk` follows the internal oscillator through a two-flop synchronizer and has the oscillator's period.
- R5: When a write changes the stop bit relative to the requested setting, the divider code in that write is ignored and the previous divider code is kept.
- R6: `sw_done` goes to 0 in the cycle after a write that requests a setting different from the active one. It returns to 1 once the switch has taken effect, and stays 1 while no write occurs.
- R7: A switch between settings that are not both stopped takes effect only on a crystal edge where the new setting's level equals the current `card_clk`, and `card_clk` keeps its value on that edge.
- R8: Divider code 11 behaves exactly like code 10 (divide by eight).
- R9: While the clock is stopped, a write that changes only the stop level takes effect on the next crystal edge, and `card_clk` moves to the new level there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_int | input | 1 | Internal oscillator clock, asynchronous to `clk_xtal` |
| cfg_wr | input | 1 | One-cycle write strobe for the configuration word |
| cfg_div | input | 2 | Divider code: 00 /2, 01 /4, 10 /8, 11 /8 |
| cfg_stop | input | 1 | 1 requests a stopped card clock |
| cfg_stop_high | input | 1 | Level of the stopped clock: 1 high, 0 low |
| cfg_int_sel | input | 1 | 1 selects the internal oscillator when running |
| card_clk | output | 1 | Clock delivered to the card |
| sw_done | output | 1 | High when the active setting equals the requested one |

## Verification
On every cycle the assertions check that a stopped setting holds `card_clk` at its level, that a running switch never moves `card_clk` on the edge where it takes effect, that a start or stop write leaves the divider code unchanged, and that the completion flag cannot drop without a write. The actual rates (periods of 2, 4, 8 and the oscillator period), the synchronizer delay, the handling of the reserved code, and the exact cycle on which each pending switch lands can only be shown by the bench. It does this by driving a sequence of settings and comparing both outputs against a cycle-level behavioural model on every cycle.

// File: rtl/cks_pkg.sv
package cks_pkg;

    // Number of divided taps offered (/2, /4, /8)
    localparam int NUM_TAPS = 3;
    localparam int TAP_IDX_W = $clog2(NUM_TAPS);

    typedef enum logic [1:0] {
        DIV_BY2  = 2'b00,
        DIV_BY4  = 2'b01,
        DIV_BY8  = 2'b10,
        DIV_RSVD = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic     int_sel;
        logic     stop;
        logic     stop_high;
        div_sel_e div;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{
        int_sel:   1'b0,
        stop:      1'b1,
        stop_high: 1'b0,
        div:       DIV_BY2
    };

    // Tap index for a divider code; the reserved code maps to the slowest tap
    function automatic logic [TAP_IDX_W-1:0] tap_index(div_sel_e d);
        case (d)
            DIV_BY2: tap_index = TAP_IDX_W'(0);
            DIV_BY4: tap_index = TAP_IDX_W'(1);
            default: tap_index = TAP_IDX_W'(NUM_TAPS - 1);
        endcase
    endfunction

    // Level a setting presents on the current cycle
    function automatic logic cfg_level(clk_cfg_t c, logic [NUM_TAPS-1:0] taps, logic osc);
        if (c.stop)
            cfg_level = c.stop_high;
        else if (c.int_sel)
            cfg_level = osc;
        else
            cfg_level = taps[tap_index(c.div)];
    endfunction

endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cks_divider.sv
module cks_divider
    import cks_pkg::*;
#(
    parameter int CNT_W = NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] taps
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'(1);
    end

    // Bit k of a free-running counter has a period of 2^(k+1) cycles
    generate
        for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
            assign taps[k] = cnt_q[k];
        end
    endgenerate
endmodule

// File: rtl/cks_cfg_reg.sv
module cks_cfg_reg
    import cks_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  clk_cfg_t wr_cfg,
    output clk_cfg_t pend_q
);
    clk_cfg_t pend_d;

    // A start/stop write may not move the divider code
    always_comb begin
        pend_d = pend_q;
        if (wr) begin
            pend_d = wr_cfg;
            if (wr_cfg.stop != pend_q.stop)
                pend_d.div = pend_q.div;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= CFG_RESET;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/cks_switch.sv
module cks_switch
    import cks_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  clk_cfg_t            pend,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                osc_s,
    output clk_cfg_t            act_q,
    output logic                clk_q
);
    logic lvl_act;
    logic lvl_pend;
    logic take;

    always_comb begin
        lvl_act  = cfg_level(act_q, taps, osc_s);
        lvl_pend = cfg_level(pend, taps, osc_s);
        // Running switches wait for matching levels; stop-to-stop is a single step
        take     = (pend != act_q) &&
                   ((lvl_pend == clk_q) || (act_q.stop && pend.stop));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= CFG_RESET;
            clk_q <= 1'b0;
        end else if (take) begin
            act_q <= pend;
            clk_q <= lvl_pend;
        end else begin
            clk_q <= lvl_act;
        end
    end
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
    import cks_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_xtal,
    input  logic       rst,
    input  logic       clk_int,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_div,
    input  logic       cfg_stop,
    input  logic       cfg_stop_high,
    input  logic       cfg_int_sel,
    output logic       card_clk,
    output logic       sw_done
);
    clk_cfg_t            wr_cfg;
    clk_cfg_t            pend_cfg;
    clk_cfg_t            act_cfg;
    logic [NUM_TAPS-1:0] taps;
    logic                osc_s;

    always_comb begin
        wr_cfg.int_sel   = cfg_int_sel;
        wr_cfg.stop      = cfg_stop;
        wr_cfg.stop_high = cfg_stop_high;
        wr_cfg.div       = div_sel_e'(cfg_div);
    end

    cks_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_xtal),
        .rst     (rst),
        .d_async (clk_int),
        .q_sync  (osc_s)
    );

    cks_divider #(.CNT_W(NUM_TAPS)) u_div (
        .clk  (clk_xtal),
        .rst  (rst),
        .taps (taps)
    );

    cks_cfg_reg u_cfg (
        .clk    (clk_xtal),
        .rst    (rst),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .pend_q (pend_cfg)
    );

    cks_switch u_sw (
        .clk   (clk_xtal),
        .rst   (rst),
        .pend  (pend_cfg),
        .taps  (taps),
        .osc_s (osc_s),
        .act_q (act_cfg),
        .clk_q (card_clk)
    );

    assign sw_done = (act_cfg == pend_cfg);
endmodule

// File: rtl/cks_checker.sv
module cks_checker
    import cks_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cfg_wr,
    input logic     cfg_stop,
    input logic     card_clk,
    input logic     sw_done,
    input clk_cfg_t act,
    input clk_cfg_t pend
);
    // R3: a stopped active setting pins the output to its level
    assert_stop_level_R3: assert property (@(posedge clk) disable iff (rst)
        act.stop |-> (card_clk == act.stop_high));

    // R7: the output keeps its value on the edge a running switch lands
    assert_no_runt_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(act) != act) && !($past(act.stop) && act.stop)) |-> (card_clk == $past(card_clk)));

    // R5: a start/stop write keeps the requested divider code
    assert_div_held_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr) && ($past(cfg_stop) != $past(pend.stop))) |-> (pend.div == $past(pend.div)));

    // R6: completion cannot be lost without a write
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_done && !cfg_wr) |=> sw_done);

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!card_clk && act.stop && !act.stop_high));
endmodule

bind card_clk_sel cks_checker chk_i (
    .clk      (clk_xtal),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_stop (cfg_stop),
    .card_clk (card_clk),
    .sw_done  (sw_done),
    .act      (act_cfg),
    .pend     (pend_cfg)
);

// File: tb/card_clk_sel_tb_top.sv
module card_clk_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int INT_HALF   = 8;   // internal oscillator half period in crystal cycles

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_int = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_div = 2'b00;
    logic       cfg_stop = 1'b1;
    logic       cfg_stop_high = 1'b0;
    logic       cfg_int_sel = 1'b0;
    logic       card_clk;
    logic       sw_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_sel dut_i (
        .clk_xtal      (clk),
        .rst           (rst),
        .clk_int       (clk_int),
        .cfg_wr        (cfg_wr),
        .cfg_div       (cfg_div),
        .cfg_stop      (cfg_stop),
        .cfg_stop_high (cfg_stop_high),
        .cfg_int_sel   (cfg_int_sel),
        .card_clk      (card_clk),
        .sw_done       (sw_done)
    );

    // Internal oscillator, toggled away from the crystal rising edge
    int int_cnt = 0;
    always @(negedge clk) begin
        int_cnt++;
        if (int_cnt == INT_HALF) begin
            int_cnt = 0;
            clk_int <= ~clk_int;
        end
    end

    task automatic check(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt;
    bit m_s1, m_s2, m_clk, m_done;
    int a_i, a_s, a_h, a_d;
    int p_i, p_s, p_h, p_d;

    function automatic bit lv(int i, int s, int h, int d);
        int idx;
        if (s != 0) return bit'(h);
        if (i != 0) return m_s2;
        idx = (d > 2) ? 2 : d;
        return bit'((m_cnt >> idx) & 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_clk = 0;
            a_i = 0; a_s = 1; a_h = 0; a_d = 0;
            p_i = 0; p_s = 1; p_h = 0; p_d = 0;
        end else begin
            bit same, lp;
            same = (a_i == p_i) && (a_s == p_s) && (a_h == p_h) && (a_d == p_d);
            lp   = lv(p_i, p_s, p_h, p_d);
            if (!same && ((lp == m_clk) || (a_s != 0 && p_s != 0))) begin
                a_i = p_i; a_s = p_s; a_h = p_h; a_d = p_d;
                m_clk = lp;
            end else begin
                m_clk = lv(a_i, a_s, a_h, a_d);
            end
            if (cfg_wr) begin
                if (int'(cfg_stop) == p_s) p_d = int'(cfg_div);
                p_i = int'(cfg_int_sel); p_s = int'(cfg_stop); p_h = int'(cfg_stop_high);
            end
            m_cnt = (m_cnt + 1) % 8;
            m_s2 = m_s1; m_s1 = clk_int;
        end
        m_done = (a_i == p_i) && (a_s == p_s) && (a_h == p_h) && (a_d == p_d);
    end

    // R7 / R6: cycle-by-cycle comparison
    always @(negedge clk) begin
        if (model_on) begin
            check("R7 card_clk vs model", int'(card_clk), int'(m_clk));
            check("R6 sw_done vs model", int'(sw_done), int'(m_done));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] d, input logic s, input logic h, input logic i);
        @(negedge clk);
        cfg_div = d; cfg_stop = s; cfg_stop_high = h; cfg_int_sel = i;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic period(output int p);
        logic prev;
        bit   rise;
        int   c;
        prev = card_clk;
        c = 0;
        do begin
            @(negedge clk); c++;
            rise = !prev && card_clk; prev = card_clk;
        end while (!rise && c < 200);
        c = 0;
        do begin
            @(negedge clk); c++;
            rise = !prev && card_clk; prev = card_clk;
        end while (!rise && c < 200);
        p = c;
    endtask

    task automatic hold_level(string tag, int lvl, int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check(tag, int'(card_clk), lvl);
        end
    endtask

    task automatic settle();
        int c;
        c = 0;
        while (!sw_done && c < 100) begin
            @(negedge clk); c++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p;
        repeat (5) @(negedge clk);
        // R1: reset state while held
        check("R1 card_clk in reset", int'(card_clk), 0);
        check("R1 sw_done in reset", int'(sw_done), 1);
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        check("R1 card_clk after reset", int'(card_clk), 0);
        check("R1 sw_done after reset", int'(sw_done), 1);

        // R2: start at /2
        wr(2'b00, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R2 period div2", p, 2);
        // R6: change to /4, flag low right after the write
        wr(2'b01, 1'b0, 1'b0, 1'b0);
        check("R6 sw_done low after write", int'(sw_done), 0);
        settle();
        check("R6 sw_done high after switch", int'(sw_done), 1);
        period(p); check("R2 period div4", p, 4);
        wr(2'b10, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R2 period div8", p, 8);
        wr(2'b01, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R2 period div4 again", p, 4);
        // R8: reserved code
        wr(2'b11, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R8 period code 11", p, 8);
        // R6: no write keeps flag high
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R6 sw_done stays high", int'(sw_done), 1);
        end

        // R3: stop high
        wr(2'b11, 1'b1, 1'b1, 1'b0);
        settle();
        hold_level("R3 stopped high", 1, 12);
        // R9: level change while stopped lands on the next edge
        wr(2'b11, 1'b1, 1'b0, 1'b0);
        check("R9 level right after write edge", int'(card_clk), 1);
        @(negedge clk);
        check("R9 new level next edge", int'(card_clk), 0);
        hold_level("R3 stopped low", 0, 12);

        // R5: restart with a different divider code in the write
        wr(2'b00, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R5 divider kept on restart", p, 8);

        // R4: internal oscillator
        wr(2'b11, 1'b0, 1'b0, 1'b1);
        settle();
        period(p); check("R4 internal period", p, 2*INT_HALF);
        period(p); check("R4 internal period repeat", p, 2*INT_HALF);
        wr(2'b00, 1'b0, 1'b0, 1'b0);
        settle();
        period(p); check("R2 back to div2 from internal", p, 2);
        // R3: stop from internal at high level
        wr(2'b00, 1'b0, 1'b0, 1'b1);
        settle();
        wr(2'b00, 1'b1, 1'b1, 1'b1);
        settle();
        hold_level("R3 stopped high from internal", 1, 10);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule